// File: doc/BRIEF.md
# Serial Memory Read Responder

This block is the device side of an SPI-style serial memory that answers read commands. A host drops chip select, clocks in a one-byte command and a two-byte start location, and then keeps clocking to receive data bytes from an 8192 x 8 storage array. The block advances through the array by itself, one byte after another. After the last location it continues at location zero, so a single command can stream the whole array, and further bytes after that, for as long as chip select stays low.

The block runs on the serial clock. Chip select acts as its asynchronous reset, so raising it ends any transfer at once. A separate parallel load port, clocked by its own clock, presets the array contents. A busy input reports that a write cycle is in progress. While it is high, a read command is refused and the block stays silent until the next transaction.

Top module: `spi_read_slave`

## Requirements
- R1: After chip select falls, the block samples `sdi` on rising `sclk` edges. The first eight bits, MSB first, are the command. The next sixteen bits, MSB first, are the start location. Together they use clock periods 0 to 23.
- R2: For the read command 8'h03, the MSB of the addressed byte is driven on `sdo` after the falling `sclk` edge that ends period 23, so it is valid before the rising edge of period 24. The following bits go out MSB first, one per period, and change only on falling edges.
- R3: While chip select stays low, each completed byte is followed directly, with no idle period, by the byte at the next location.
- R4: The location after 8191 is 0.
- R5: `sdo_oe` is low and `sdo` is high impedance while chip select is high and throughout the command and address periods.
- R6: Raising chip select at any point, including mid-byte, drops `sdo_oe` at once. The next transaction starts fresh from its own command and address.
- R7: Location bits 15:13 have no effect on which byte is read.
- R8: If `wip` is high on the rising edge of period 7, the read is refused and `sdo_oe` stays low until chip select rises.
- R9: Any command other than 8'h03 is ignored, and `sdo_oe` stays low until chip select rises.
- R10: A read may start at any location, without alignment.
- R11: A rising `load_clk` edge with `load_we` high stores `load_data` at `load_addr`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| load_clk | input | 1 | Clock of the preset port |
| load_we | input | 1 | Preset write strobe |
| load_addr | input | 13 | Preset location |
| load_data | input | 8 | Preset byte |
| wip | input | 1 | Write cycle in progress; refuses reads |
| cs_n | input | 1 | Chip select, active low; high resets the block |
| sclk | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high impedance when idle |
| sdo_oe | output | 1 | High while `sdo` is driven |

## Verification
The assertions rely on the host keeping to mode 0. They assume `sclk` is low whenever chip select changes, `sdi` and `wip` settle while `sclk` is low, and the preset port is quiet during a serial transaction. The bench meets these conditions by moving chip select, `sdi` and `wip` only in the low half of `sclk`. It also finishes every preset write before the first serial transfer begins, and keeps `wip` constant within each transaction.

// File: rtl/spird_pkg.sv
package spird_pkg;
    localparam int MEM_AW   = 13;
    localparam int DATA_W   = 8;
    localparam int CMD_W    = 8;
    localparam int WIRE_AW  = 16;
    localparam int HDR_BITS = CMD_W + WIRE_AW;
    localparam int CNT_W    = $clog2(HDR_BITS + 1);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int SH_W     = ((MEM_AW > CMD_W) ? MEM_AW : CMD_W) - 1;

    localparam logic [CMD_W-1:0] OP_READ = 8'h03;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;

    function automatic logic accept_cmd(input logic [CMD_W-1:0] op, input logic busy);
        return (op == OP_READ) && !busy;
    endfunction
endpackage

// File: rtl/spird_frontend.sv
module spird_frontend
    import spird_pkg::*;
(
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              wip,
    output phase_t            phase,
    output logic              addr_load,
    output logic [MEM_AW-1:0] addr_val
);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;
    logic [CMD_W-1:0] op_now;

    assign op_now    = {sh[CMD_W-2:0], sdi};
    assign addr_val  = {sh[MEM_AW-2:0], sdi};
    assign addr_load = (phase == PH_ADDR) && (cnt == LAST_HDR);

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            cnt   <= '0;
            sh    <= '0;
            phase <= PH_CMD;
        end else begin
            sh <= {sh[SH_W-2:0], sdi};
            case (phase)
                PH_CMD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_CMD)
                        phase <= accept_cmd(op_now, wip) ? PH_ADDR : PH_SKIP;
                end
                PH_ADDR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_HDR)
                        phase <= PH_DATA;
                end
                default: ;
            endcase
        end
    end

    assert_busy_refuses_R8: assert property (@(posedge sclk) disable iff (cs_n)
        (phase == PH_CMD && cnt == LAST_CMD && wip) |=> (phase == PH_SKIP));

    assert_count_bound_R1: assert property (@(posedge sclk) disable iff (cs_n)
        (cnt <= LAST_HDR + 1'b1));
endmodule

// File: rtl/spird_addr_ctr.sv
module spird_addr_ctr
    import spird_pkg::*;
(
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              load,
    input  logic [MEM_AW-1:0] load_val,
    input  logic              run,
    output logic [MEM_AW-1:0] addr,
    output logic [BIT_W-1:0]  bidx
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            addr <= '0;
            bidx <= '0;
        end else if (load) begin
            addr <= load_val;
            bidx <= '0;
        end else if (run) begin
            if (bidx == LAST_BIT) begin
                bidx <= '0;
                addr <= addr + 1'b1;
            end else begin
                bidx <= bidx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spird_store.sv
module spird_store
    import spird_pkg::*;
(
    input  logic              load_clk,
    input  logic              load_we,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge load_clk) begin
        if (load_we)
            mem[load_addr] <= load_data;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spird_serializer.sv
module spird_serializer
    import spird_pkg::*;
(
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              run,
    input  logic [DATA_W-1:0] rdata,
    input  logic [BIT_W-1:0]  bidx,
    output logic              sdo,
    output logic              sdo_oe
);
    logic             bit_q;
    logic             oe_q;
    logic [BIT_W-1:0] sel;

    assign sel = BIT_W'(DATA_W - 1) - bidx;

    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            bit_q <= rdata[sel];
            oe_q  <= run;
        end
    end

    assign sdo_oe = oe_q;
    assign sdo    = oe_q ? bit_q : 1'bz;
endmodule

// File: rtl/spi_read_slave.sv
module spi_read_slave
    import spird_pkg::*;
(
    input  logic        load_clk,
    input  logic        load_we,
    input  logic [12:0] load_addr,
    input  logic [7:0]  load_data,
    input  logic        wip,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    phase_t            phase;
    logic              addr_load;
    logic [MEM_AW-1:0] addr_val;
    logic [MEM_AW-1:0] mem_addr;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] rdata;
    logic              in_data;

    assign in_data = (phase == PH_DATA);

    spird_frontend u_front (
        .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .wip(wip),
        .phase(phase), .addr_load(addr_load), .addr_val(addr_val)
    );

    spird_addr_ctr u_ctr (
        .sclk(sclk), .cs_n(cs_n), .load(addr_load), .load_val(addr_val),
        .run(in_data), .addr(mem_addr), .bidx(bidx)
    );

    spird_store u_store (
        .load_clk(load_clk), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .raddr(mem_addr), .rdata(rdata)
    );

    spird_serializer u_ser (
        .sclk(sclk), .cs_n(cs_n), .run(in_data), .rdata(rdata),
        .bidx(bidx), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    assert_header_quiet_R5: assert property (@(posedge sclk) disable iff (cs_n)
        (phase != PH_DATA) |-> !sdo_oe);

    assert_ignored_quiet_R9: assert property (@(posedge sclk) disable iff (cs_n)
        (phase == PH_SKIP) |-> !sdo_oe);

    assert_driving_in_stream_R2: assert property (@(posedge sclk) disable iff (cs_n)
        (phase == PH_DATA && $past(phase) == PH_DATA) |-> sdo_oe);

    assert_addr_hold_midbyte_R3: assert property (@(posedge sclk) disable iff (cs_n)
        (phase == PH_DATA && bidx != '0) |-> $stable(mem_addr));

    assert_wrap_to_zero_R4: assert property (@(posedge sclk) disable iff (cs_n)
        (phase == PH_DATA && bidx == LAST_BIT && mem_addr == '1) |=> (mem_addr == '0));
endmodule

// File: tb/sim_spi_read_slave.sv
module sim_spi_read_slave;
    logic        clk = 1'b0;
    logic        load_we = 1'b0;
    logic [12:0] load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        wip = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    wire         sdo;
    wire         sdo_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [8192];

    always #4 clk = ~clk;

    spi_read_slave u0 (
        .load_clk(clk), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .wip(wip), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    localparam int NV = 7;
    localparam logic [7:0]  V_OP   [NV] = '{8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h0B, 8'h03};
    localparam logic [15:0] V_ADDR [NV] = '{16'h0000, 16'h1234, 16'h1FFE, 16'hE005, 16'h0100, 16'h0100, 16'h0FFF};
    localparam int          V_N    [NV] = '{3, 2, 4, 2, 2, 2, 1};
    localparam logic        V_BUSY [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam string       V_TAG  [NV] = '{"R1", "R10", "R4", "R7", "R8", "R9", "R10"};

    function automatic logic [7:0] pattern(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], a[12:10]};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic preset(input logic [12:0] a, input logic [7:0] d);
        @(posedge clk);
        #1;
        load_addr = a;
        load_data = d;
        load_we   = 1'b1;
        ref_mem[a] = d;
        @(posedge clk);
        #1;
        load_we = 1'b0;
    endtask

    // Full transaction; extra_bits > 0 aborts mid-byte after the last full byte.
    task automatic run_read(input logic [7:0] op, input logic [15:0] a, input int nbytes,
                            input logic busy, input int extra_bits, input string tag);
        logic [23:0] hdr;
        logic        hdr_quiet;
        logic        accept;
        logic [12:0] loc;
        hdr       = {op, a};
        hdr_quiet = 1'b1;
        accept    = (op == 8'h03) && !busy;
        loc       = a[12:0];
        wip       = busy;
        cs_n      = 1'b0;
        #4;
        for (int i = 0; i < 24; i++) begin
            sdi = hdr[23 - i];
            #2;
            if (sdo_oe !== 1'b0) hdr_quiet = 1'b0;
            #2 sclk = 1'b1;
            #4 sclk = 1'b0;
        end
        check(hdr_quiet, "R5", {tag, " header quiet"}, int'(hdr_quiet), 1);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] got;
            logic       oe_seen;
            logic       oe_all;
            got     = '0;
            oe_seen = 1'b0;
            oe_all  = 1'b1;
            for (int k = 0; k < 8; k++) begin
                #2;
                got[7 - k] = sdo;
                if (sdo_oe === 1'b1) oe_seen = 1'b1;
                if (sdo_oe !== 1'b1) oe_all = 1'b0;
                #2 sclk = 1'b1;
                #4 sclk = 1'b0;
            end
            if (accept) begin
                // R2 R3: MSB-first byte at start + b, back to back
                check(oe_all && got === ref_mem[loc], tag, "data byte",
                      int'(got), int'(ref_mem[loc]));
            end else begin
                check(!oe_seen, tag, "refused read stays quiet", int'(oe_seen), 0);
            end
            loc = loc + 13'd1;
        end
        for (int k = 0; k < extra_bits; k++) begin
            #2 sclk = 1'b1;
            #4 sclk = 1'b0;
            #2;
        end
        #2 cs_n = 1'b1;
        wip = 1'b0;
        #2;
        if (extra_bits > 0)
            check(sdo_oe === 1'b0, "R6", "release mid-byte", int'(sdo_oe), 0);
        #8;
    endtask

    initial begin
        #200000;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        #2;
        check(sdo_oe === 1'b0, "R5", "idle with chip select high", int'(sdo_oe), 0);
        for (int a = 0; a < 8192; a++) begin
            @(posedge clk);
            #1;
            load_addr  = 13'(a);
            load_data  = pattern(13'(a));
            load_we    = 1'b1;
            ref_mem[a] = pattern(13'(a));
        end
        @(posedge clk);
        #1 load_we = 1'b0;
        #16;

        for (int v = 0; v < NV; v++)
            run_read(V_OP[v], V_ADDR[v], V_N[v], V_BUSY[v], 0, V_TAG[v]);

        // R6: abort mid-byte, then a fresh transaction
        run_read(8'h03, 16'h0040, 1, 1'b0, 3, "R6");
        run_read(8'h03, 16'h0050, 2, 1'b0, 0, "R6");

        // R11: preset port overwrite becomes visible to reads
        preset(13'h0AAA, 8'h5A);
        #16;
        run_read(8'h03, 16'h0AAA, 1, 1'b0, 0, "R11");

        // R4: wrap in a long stream from the top location
        run_read(8'h03, 16'h1FFF, 3, 1'b0, 0, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule